// File: doc/BRIEF.md
# Crystal Oscillator Fault Monitor

This block supervises up to two external crystal oscillators. A primary crystal is always present. A secondary crystal is present when a parameter says so. The block runs on a fast reference clock. It receives one pulse per detected oscillator edge, already synchronised to that reference clock, for each crystal. A crystal counts as faulty when the pulses for that crystal stop for a set number of reference cycles. While any fault is present, the block drives a signal that makes the clock tree fall back to the internal digitally controlled oscillator with its internal bias resistor.

The block also holds a sticky fault flag and an interrupt enable bit. The flag starts set at power-on reset. Software can set it or clear it through strobes. The hardware never clears it. A clear strobe has no effect while either detector reports a fault. A non-maskable interrupt request is raised while both the flag and the enable are set. When the interrupt is accepted, the enable is cleared so that the request does not fire again until software enables it once more.

Top module: `xtal_fault_monitor`

## Requirements
- R1: During and right after power-on reset, `fault_flag` is 1, `nmi_req` is 0 and `force_dco` is 0.
- R2: When no `xt1_edge` pulse occurs for LIMIT (default 50) consecutive reference cycles, `force_dco` goes to 1 after the LIMIT-th cycle. After LIMIT-1 such cycles it is still 0.
- R3: When edges arrive at most every LIMIT cycles, no fault is declared.
- R4: The secondary detector (HAS_XT2=1) behaves like the primary one on `xt2_edge`. Its fault is ORed into `force_dco` and into the flag.
- R5: While `xt1_off` or `xt2_off` is 1, the matching detector is held cleared and reports no fault. This holds even when that crystal produces no edges.
- R6: A detector fault sets `fault_flag` one cycle after `force_dco` rises. The flag then stays 1 after the fault goes away.
- R7: A `flag_clr` strobe in a cycle where any detector reports a fault leaves `fault_flag` at 1.
- R8: A `flag_clr` strobe in a cycle with no fault clears `fault_flag` on the next clock edge.
- R9: `nmi_req` is 1 exactly while `fault_flag` and the enable bit are both 1. The enable bit resets to 0, is set by `en_set` and is cleared by `en_clr`.
- R10: An `irq_ack` pulse clears the enable bit. `irq_ack` and `en_clr` take priority over `en_set` in the same cycle.
- R11: One edge pulse on a faulted crystal removes `force_dco` on the next clock edge.
- R12: A `flag_set` strobe sets `fault_flag` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low power-on reset |
| xt1_edge | input | 1 | One-cycle pulse per primary crystal edge |
| xt2_edge | input | 1 | One-cycle pulse per secondary crystal edge |
| xt1_off | input | 1 | Primary crystal switched off |
| xt2_off | input | 1 | Secondary crystal switched off |
| flag_set | input | 1 | Software strobe that sets the fault flag |
| flag_clr | input | 1 | Software strobe that clears the fault flag |
| en_set | input | 1 | Software strobe that sets the interrupt enable |
| en_clr | input | 1 | Software strobe that clears the interrupt enable |
| irq_ack | input | 1 | Interrupt-accepted pulse |
| fault_flag | output | 1 | Sticky oscillator fault flag |
| nmi_req | output | 1 | Non-maskable interrupt request |
| force_dco | output | 1 | Forces fail-safe internal oscillator selection |

## Verification
A detector counter that is off by one shows up at `force_dco` exactly one cycle early or late at the LIMIT boundary. The bench therefore samples that output at LIMIT-1 and at LIMIT silent cycles. A flag register that ignores the fault gate, or that clears itself, is visible at `fault_flag` in the cycle right after a blocked clear or after the fault ends. A wrong enable priority or a missing acknowledge shows at `nmi_req` one cycle after the strobe.

// File: rtl/xtal_fault_monitor.sv
module xtal_fault_monitor #(
  parameter int LIMIT   = 50,
  parameter bit HAS_XT2 = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xt1_edge,
  input  logic xt2_edge,
  input  logic xt1_off,
  input  logic xt2_off,
  input  logic flag_set,
  input  logic flag_clr,
  input  logic en_set,
  input  logic en_clr,
  input  logic irq_ack,
  output logic fault_flag,
  output logic nmi_req,
  output logic force_dco
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [CW-1:0] cnt1;
  logic fault1, fault2, any_fault, enable;

  // primary detector: saturating silence counter
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    cnt1 <= '0;
    else if (xt1_off || xt1_edge)  cnt1 <= '0;
    else if (cnt1 != CMAX)         cnt1 <= cnt1 + 1'b1;

  assign fault1 = (cnt1 == CMAX);

  generate
    if (HAS_XT2) begin : g_xt2
      logic [CW-1:0] cnt2;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                    cnt2 <= '0;
        else if (xt2_off || xt2_edge)  cnt2 <= '0;
        else if (cnt2 != CMAX)         cnt2 <= cnt2 + 1'b1;
      assign fault2 = (cnt2 == CMAX);

      p_cnt2_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt2 <= CMAX);
    end else begin : g_no_xt2
      assign fault2 = 1'b0;
    end
  endgenerate

  assign any_fault = fault1 | fault2;
  assign force_dco = any_fault;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   fault_flag <= 1'b1;
    else if (any_fault || flag_set) fault_flag <= 1'b1;
    else if (flag_clr)            fault_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 enable <= 1'b0;
    else if (irq_ack || en_clr) enable <= 1'b0;
    else if (en_set)            enable <= 1'b1;

  assign nmi_req = fault_flag & enable;

  p_cnt1_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt1 <= CMAX);
  p_edge_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xt1_edge |=> !fault1);
  p_off_xt1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xt1_off |=> !fault1);
  p_off_xt2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xt2_off |=> !fault2);
  p_fault_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_dco |=> fault_flag);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !flag_clr) |=> fault_flag);
  p_ack_drops_nmi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !nmi_req);
  p_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> fault_flag);

endmodule

// File: tb/test_xtal_fault_monitor.sv
module test_xtal_fault_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xt1_edge = 0, xt2_edge = 0, xt1_off = 0, xt2_off = 0;
  logic flag_set = 0, flag_clr = 0, en_set = 0, en_clr = 0, irq_ack = 0;
  logic fault_flag, nmi_req, force_dco;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic f; logic n; logic d; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  xtal_fault_monitor i_xtal_fault_monitor (
    .clk, .rst_n, .xt1_edge, .xt2_edge, .xt1_off, .xt2_off,
    .flag_set, .flag_clr, .en_set, .en_clr, .irq_ack,
    .fault_flag, .nmi_req, .force_dco);

  task automatic expect_out(input string tag, input logic f, input logic n, input logic d);
    exp_t e;
    e.f = f; e.n = n; e.d = d; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (fault_flag !== e.f || nmi_req !== e.n || force_dco !== e.d) begin
        failures++;
        $display("FAIL %s: flag/nmi/force actual=%b%b%b expected=%b%b%b",
                 e.tag, fault_flag, nmi_req, force_dco, e.f, e.n, e.d);
      end
    end
  end

  task automatic cyc(input logic e1, input logic e2, input logic fs, input logic fc,
                     input logic es, input logic ec, input logic ack);
    @(negedge clk);
    xt1_edge = e1; xt2_edge = e2; flag_set = fs; flag_clr = fc;
    en_set = es; en_clr = ec; irq_ack = ack;
    @(posedge clk);
    #2;
    xt1_edge = 0; xt2_edge = 0; flag_set = 0; flag_clr = 0;
    en_set = 0; en_clr = 0; irq_ack = 0;
  endtask

  task automatic run(input int n, input int p1, input int p2);
    for (int i = 0; i < n; i++)
      cyc(p1 != 0 && i % p1 == 0, p2 != 0 && i % p2 == 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #2 expect_out("R1 in reset", 1, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2 expect_out("R1 after release", 1, 0, 0);

    run(100, 10, 10);
    expect_out("R3 regular edges", 1, 0, 0);
    cyc(1, 1, 0, 1, 0, 0, 0);
    expect_out("R8 clear with no fault", 0, 0, 0);

    // R2 boundary on primary crystal
    cyc(1, 1, 0, 0, 0, 0, 0);
    run(49, 0, 10);
    expect_out("R2 LIMIT-1 silent cycles", 0, 0, 0);
    run(1, 0, 10);
    expect_out("R2 LIMIT silent cycles", 0, 0, 1);
    run(1, 0, 10);
    expect_out("R6 flag one cycle later", 1, 0, 1);
    cyc(0, 1, 0, 1, 0, 0, 0);
    expect_out("R7 clear blocked by fault", 1, 0, 1);
    cyc(1, 1, 0, 0, 0, 0, 0);
    expect_out("R11 edge removes force", 1, 0, 0);
    run(5, 1, 1);
    expect_out("R6 flag sticky", 1, 0, 0);
    cyc(1, 1, 0, 1, 0, 0, 0);
    expect_out("R8 clear after recovery", 0, 0, 0);

    // R4 secondary detector
    run(50, 10, 0);
    expect_out("R4 secondary fault", 0, 0, 1);
    run(1, 10, 0);
    expect_out("R4 secondary sets flag", 1, 0, 1);
    xt2_off = 1;
    cyc(1, 0, 0, 0, 0, 0, 0);
    expect_out("R5 secondary off clears fault", 1, 0, 0);
    cyc(1, 0, 0, 1, 0, 0, 0);
    expect_out("R5 clear accepted while off", 0, 0, 0);
    run(80, 10, 0);
    expect_out("R5 secondary off silent", 0, 0, 0);
    xt2_off = 0;
    cyc(1, 1, 0, 0, 0, 0, 0);
    xt1_off = 1;
    run(80, 0, 10);
    expect_out("R5 primary off silent", 0, 0, 0);
    xt1_off = 0;
    cyc(1, 1, 0, 0, 0, 0, 0);

    // R9 / R10 / R12 interrupt path
    cyc(1, 1, 0, 0, 1, 0, 0);
    expect_out("R9 enable without flag", 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0, 0);
    expect_out("R12 flag_set, R9 nmi", 1, 1, 0);
    cyc(1, 1, 0, 0, 0, 0, 1);
    expect_out("R10 ack clears enable", 1, 0, 0);
    cyc(1, 1, 0, 0, 1, 0, 0);
    expect_out("R9 re-enable", 1, 1, 0);
    cyc(1, 1, 0, 0, 0, 1, 0);
    expect_out("R9 en_clr", 1, 0, 0);
    cyc(1, 1, 0, 0, 1, 0, 1);
    expect_out("R10 ack beats en_set", 1, 0, 0);
    cyc(1, 1, 0, 0, 1, 0, 0);
    cyc(1, 1, 0, 1, 0, 0, 0);
    expect_out("R9 nmi drops with flag", 0, 0, 0);
    run(50, 0, 10);
    expect_out("R2 fault before flag", 0, 0, 1);
    run(1, 0, 10);
    expect_out("R9 fault raises nmi", 1, 1, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule